// File: doc/BRIEF.md
# Vector Element Move Unit

This unit executes the element-level move operations of a SIMD extension. The extension has thirty-two 128-bit vector registers and thirty-two scalar registers, and both register files live inside the unit. Each instruction word carries a 6-bit field that encodes both the element size and the element index through a prefix code. Bits [21:16] hold this field, and bits [25:22] select the operation. The operations are:

- signed copy of a vector element into a scalar register;
- unsigned copy of a vector element into a scalar register;
- insert of a scalar value into one element;
- insert of element 0 of another vector into one element;
- splat of one element across a whole register;
- whole-register move.

Any encoding that is not legal is reported as a reserved-instruction exception and changes no state. When the write-protect enable input is high, every vector write sets the bit of the destination register in a sticky modified mask.

An instruction is offered with `in_valid` for one cycle. The register files update at that clock edge, and `done` (with `exc`) is raised in the following cycle. The rest of the core loads scalar registers through a load port and reads both files through combinational read ports.

Top module: `vem_unit`

## Requirements
- R1: The field at bits [21:16] decodes as follows: `0xxxxx` selects bytes with index [4:0]; `10xxxx` selects halfwords with index [3:0]; `110xxx` selects words with index [2:0]; `1110xx` selects doublewords with index [1:0]; `111110` selects the whole-register group. The values `111100`, `111101` and `111111` raise `exc` and leave every register and the mask unchanged.
- R2: An element index at or above 128 divided by the element width (16, 8, 4 or 2) raises `exc` with no state change.
- R3: Signed copy (op 2) writes the selected element, sign-extended to 32 bits, into the scalar register named by bits [10:6]. The source vector is named by bits [15:11].
- R4: Unsigned copy (op 3) writes the selected element, zero-extended to 32 bits, into the scalar destination.
- R5: Insert (op 4) writes the low bits of the scalar register named by bits [15:11] into element n of the vector named by bits [10:6]. All other elements are unchanged.
- R6: Insert-vector (op 5) writes element 0 of the source vector into element n of the destination vector. All other elements are unchanged.
- R7: Splat (op 1) writes element n of the source vector into every element of the destination vector.
- R8: In the whole-register group, op 0 copies all 128 bits of the source vector to the destination vector.
- R9: When `wp_en` is high, a completed vector write sets bit [10:6] of `mod_mask`. The mask is otherwise unchanged, its bits never clear, and it resets to zero.
- R10: With 32-bit scalars, doubleword copy and insert raise `exc`. Doubleword splat and insert-vector remain legal.
- R11: Scalar register 0 always reads zero, and copies to it have no effect.
- R12: `done` is high exactly in the cycle after `in_valid` and `exc` is only high with `done`. When a copy and the load port target the same scalar register in the same cycle, the copy result is kept. An insert reads the scalar value from before a same-cycle load.
- R13: These raise `exc`: an op code other than 1 to 5 in the element group, an op code other than 0 in the whole-register group, and any nonzero bit in [31:26] or [5:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered this cycle |
| in_instr | input | 32 | Instruction word |
| wp_en | input | 1 | Write-protect tracking enable |
| ld_en | input | 1 | Scalar load port enable |
| ld_idx | input | 5 | Scalar load register number |
| ld_data | input | 32 | Scalar load value |
| xrd_idx | input | 5 | Scalar read port register number |
| xrd_data | output | 32 | Scalar read port value |
| vrd_idx | input | 5 | Vector read port register number |
| vrd_data | output | 128 | Vector read port value |
| done | output | 1 | Instruction completed last cycle |
| exc | output | 1 | Reserved-instruction exception, with done |
| mod_mask | output | 32 | Sticky modified-vector mask |

## Verification
The scalar load port and an instruction can both act on the scalar file in the same cycle. A copy can write the register that the load port is writing, and an insert can read the register that the load port is updating. The bench drives both cases in one cycle: a copy and a load to the same register, then an insert whose scalar source is being loaded. It judges the result by reading the scalar file and the destination vector through the read ports. The expected outcome is that the copy value survives and that the insert uses the value from before the load.

// File: rtl/vem_pkg.sv
package vem_pkg;
  typedef enum logic [2:0] {
    OP_NONE, OP_SPLAT, OP_COPYS, OP_COPYU, OP_INS, OP_INSV, OP_MOVE
  } vem_op_e;

  localparam logic [3:0] OPC_MOVE  = 4'd0;
  localparam logic [3:0] OPC_SPLAT = 4'd1;
  localparam logic [3:0] OPC_COPYS = 4'd2;
  localparam logic [3:0] OPC_COPYU = 4'd3;
  localparam logic [3:0] OPC_INS   = 4'd4;
  localparam logic [3:0] OPC_INSV  = 4'd5;

  localparam logic [5:0] FMT_WHOLE = 6'b111110;
endpackage

// File: rtl/vem_decode.sv
module vem_decode
  import vem_pkg::*;
#(
  parameter int VLEN = 128,
  parameter int XLEN = 32,
  parameter int IW   = 4
) (
  input  logic [5:0]    fmt,
  input  logic [3:0]    opc,
  input  logic [11:0]   spare,
  output logic [1:0]    sz,
  output logic [IW-1:0] idx,
  output vem_op_e       op,
  output logic          legal
);
  localparam bit NARROW = (XLEN < 64);

  logic       fmt_elem, fmt_whole, in_range, wide_bad;
  logic [4:0] idx_full;
  logic [5:0] n_elem;

  always_comb begin
    sz        = 2'd0;
    idx_full  = 5'd0;
    fmt_elem  = 1'b0;
    fmt_whole = 1'b0;
    casez (fmt)
      6'b0?????: begin sz = 2'd0; idx_full = fmt[4:0];          fmt_elem = 1'b1; end
      6'b10????: begin sz = 2'd1; idx_full = {1'b0, fmt[3:0]};  fmt_elem = 1'b1; end
      6'b110???: begin sz = 2'd2; idx_full = {2'b0, fmt[2:0]};  fmt_elem = 1'b1; end
      6'b1110??: begin sz = 2'd3; idx_full = {3'b0, fmt[1:0]};  fmt_elem = 1'b1; end
      FMT_WHOLE: fmt_whole = 1'b1;
      default:   ;
    endcase
    n_elem   = 6'(VLEN >> (3 + int'(sz)));
    in_range = ({1'b0, idx_full} < n_elem);
    op = OP_NONE;
    if (fmt_whole) begin
      if (opc == OPC_MOVE) op = OP_MOVE;
    end else if (fmt_elem) begin
      case (opc)
        OPC_SPLAT: op = OP_SPLAT;
        OPC_COPYS: op = OP_COPYS;
        OPC_COPYU: op = OP_COPYU;
        OPC_INS:   op = OP_INS;
        OPC_INSV:  op = OP_INSV;
        default:   op = OP_NONE;
      endcase
    end
    wide_bad = NARROW && (sz == 2'd3) &&
               (op == OP_COPYS || op == OP_COPYU || op == OP_INS);
    legal = (op != OP_NONE) && (fmt_whole || in_range) && !wide_bad && (spare == '0);
  end

  assign idx = idx_full[IW-1:0];
endmodule

// File: rtl/vem_elem_path.sv
module vem_elem_path
  import vem_pkg::*;
#(
  parameter int VLEN = 128,
  parameter int XLEN = 32,
  parameter int IW   = 4
) (
  input  logic [1:0]      sz,
  input  logic [IW-1:0]   idx,
  input  vem_op_e         op,
  input  logic [VLEN-1:0] vs,
  input  logic [VLEN-1:0] vd_old,
  input  logic [XLEN-1:0] xs,
  output logic [VLEN-1:0] v_new,
  output logic [XLEN-1:0] x_new,
  output logic            v_we,
  output logic            x_we
);
  localparam int NSZ = 4;

  logic [VLEN-1:0] ins_v [NSZ];
  logic [VLEN-1:0] spl_v [NSZ];
  logic [XLEN-1:0] cps   [NSZ];
  logic [XLEN-1:0] cpu   [NSZ];

  for (genvar g = 0; g < NSZ; g++) begin : g_size
    localparam int EW  = 8 << g;
    localparam int NE  = VLEN / EW;
    localparam int SW  = (NE > 1) ? $clog2(NE) : 1;
    logic [SW-1:0]   sel;
    logic [EW-1:0]   pick, put;
    logic [VLEN-1:0] ins_g, spl_g;
    assign sel  = idx[SW-1:0];
    assign pick = vs[sel*EW +: EW];
    assign put  = (op == OP_INSV) ? vs[EW-1:0] : EW'(xs);
    for (genvar e = 0; e < NE; e++) begin : g_lane
      assign ins_g[e*EW +: EW] = (sel == SW'(e)) ? put : vd_old[e*EW +: EW];
      assign spl_g[e*EW +: EW] = pick;
    end
    assign ins_v[g] = ins_g;
    assign spl_v[g] = spl_g;
    assign cps[g]   = XLEN'($signed(pick));
    assign cpu[g]   = XLEN'(pick);
  end

  always_comb begin
    v_new = vs;
    x_new = cpu[sz];
    v_we  = 1'b0;
    x_we  = 1'b0;
    case (op)
      OP_SPLAT: begin v_new = spl_v[sz]; v_we = 1'b1; end
      OP_INS,
      OP_INSV:  begin v_new = ins_v[sz]; v_we = 1'b1; end
      OP_MOVE:  begin v_new = vs;        v_we = 1'b1; end
      OP_COPYS: begin x_new = cps[sz];   x_we = 1'b1; end
      OP_COPYU: begin x_new = cpu[sz];   x_we = 1'b1; end
      default:  ;
    endcase
  end
endmodule

// File: rtl/vem_vrf.sv
module vem_vrf #(
  parameter int VLEN = 128,
  parameter int RW   = 5
) (
  input  logic            clk,
  input  logic            we,
  input  logic [RW-1:0]   waddr,
  input  logic [VLEN-1:0] wdata,
  input  logic [RW-1:0]   ra_a,
  input  logic [RW-1:0]   ra_b,
  input  logic [RW-1:0]   ra_c,
  output logic [VLEN-1:0] rd_a,
  output logic [VLEN-1:0] rd_b,
  output logic [VLEN-1:0] rd_c
);
  localparam int NREG = 1 << RW;

  logic [VLEN-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rd_a = mem[ra_a];
  assign rd_b = mem[ra_b];
  assign rd_c = mem[ra_c];
endmodule

// File: rtl/vem_xrf.sv
module vem_xrf #(
  parameter int XLEN = 32,
  parameter int RW   = 5
) (
  input  logic            clk,
  input  logic            we_ins,
  input  logic [RW-1:0]   wa_ins,
  input  logic [XLEN-1:0] wd_ins,
  input  logic            we_ld,
  input  logic [RW-1:0]   wa_ld,
  input  logic [XLEN-1:0] wd_ld,
  input  logic [RW-1:0]   ra_a,
  input  logic [RW-1:0]   ra_b,
  output logic [XLEN-1:0] rd_a,
  output logic [XLEN-1:0] rd_b
);
  localparam int NREG = 1 << RW;

  logic [XLEN-1:0] mem [NREG];
  logic            ins_en, ld_en_eff;

  // instruction port wins over the load port on the same register
  assign ins_en    = we_ins && (wa_ins != '0);
  assign ld_en_eff = we_ld && (wa_ld != '0) && !(ins_en && (wa_ins == wa_ld));

  always_ff @(posedge clk) begin
    if (ld_en_eff) mem[wa_ld]  <= wd_ld;
    if (ins_en)    mem[wa_ins] <= wd_ins;
  end

  assign rd_a = (ra_a == '0) ? '0 : mem[ra_a];
  assign rd_b = (ra_b == '0) ? '0 : mem[ra_b];
endmodule

// File: rtl/vem_unit.sv
module vem_unit
  import vem_pkg::*;
#(
  parameter int VLEN = 128,
  parameter int XLEN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [31:0]      in_instr,
  input  logic             wp_en,
  input  logic             ld_en,
  input  logic [4:0]       ld_idx,
  input  logic [XLEN-1:0]  ld_data,
  input  logic [4:0]       xrd_idx,
  output logic [XLEN-1:0]  xrd_data,
  input  logic [4:0]       vrd_idx,
  output logic [VLEN-1:0]  vrd_data,
  output logic             done,
  output logic             exc,
  output logic [31:0]      mod_mask
);
  localparam int RW   = 5;
  localparam int NREG = 1 << RW;
  localparam int IW   = $clog2(VLEN / 8);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  logic [5:0]      fmt;
  logic [3:0]      opc;
  logic [RW-1:0]   src, dst;
  logic [1:0]      sz;
  logic [IW-1:0]   idx;
  vem_op_e         op;
  logic            legal;
  logic [VLEN-1:0] vs, vd_old, v_new;
  logic [XLEN-1:0] xs, x_new;
  logic            v_we_op, x_we_op, v_we, x_we, go;

  assign opc = in_instr[25:22];
  assign fmt = in_instr[21:16];
  assign src = in_instr[15:11];
  assign dst = in_instr[10:6];
  assign go  = in_valid && rst_i_n;

  vem_decode #(.VLEN(VLEN), .XLEN(XLEN), .IW(IW)) u_dec (
    .fmt(fmt), .opc(opc), .spare({in_instr[31:26], in_instr[5:0]}),
    .sz(sz), .idx(idx), .op(op), .legal(legal)
  );

  vem_elem_path #(.VLEN(VLEN), .XLEN(XLEN), .IW(IW)) u_path (
    .sz(sz), .idx(idx), .op(op), .vs(vs), .vd_old(vd_old), .xs(xs),
    .v_new(v_new), .x_new(x_new), .v_we(v_we_op), .x_we(x_we_op)
  );

  assign v_we = go && legal && v_we_op;
  assign x_we = go && legal && x_we_op;

  vem_vrf #(.VLEN(VLEN), .RW(RW)) u_vrf (
    .clk(clk), .we(v_we), .waddr(dst), .wdata(v_new),
    .ra_a(src), .ra_b(dst), .ra_c(vrd_idx),
    .rd_a(vs), .rd_b(vd_old), .rd_c(vrd_data)
  );

  vem_xrf #(.XLEN(XLEN), .RW(RW)) u_xrf (
    .clk(clk),
    .we_ins(x_we), .wa_ins(dst), .wd_ins(x_new),
    .we_ld(ld_en && rst_i_n), .wa_ld(ld_idx), .wd_ld(ld_data),
    .ra_a(src), .ra_b(xrd_idx), .rd_a(xs), .rd_b(xrd_data)
  );

  // next state
  logic            done_d, exc_d;
  logic [NREG-1:0] mask_d;
  always_comb begin
    done_d = go;
    exc_d  = go && !legal;
    mask_d = mod_mask;
    if (v_we && wp_en) mask_d[dst] = 1'b1;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      done     <= 1'b0;
      exc      <= 1'b0;
      mod_mask <= '0;
    end else begin
      done     <= done_d;
      exc      <= exc_d;
      mod_mask <= mask_d;
    end
  end

  p_done_latency_r12: assert property (@(posedge clk) disable iff (!rst_i_n)
    in_valid |=> done);
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_i_n)
    !in_valid |=> !done);
  p_exc_with_done_r12: assert property (@(posedge clk) disable iff (!rst_i_n)
    exc |-> done);
  p_mask_sticky_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    1'b1 |=> ((mod_mask & $past(mod_mask)) == $past(mod_mask)));
  p_mask_gated_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (in_valid && !wp_en) |=> $stable(mod_mask));
  p_reserved_quiet_r1: assert property (@(posedge clk) disable iff (!rst_i_n)
    (in_valid && !legal) |=> $stable(mod_mask));
  p_bad_fmt_exc_r1: assert property (@(posedge clk) disable iff (!rst_i_n)
    (in_valid && (fmt[5:2] == 4'b1111) && (fmt != FMT_WHOLE)) |=> exc);
  if (XLEN < 64) begin : g_narrow_chk
    p_wide_scalar_exc_r10: assert property (@(posedge clk) disable iff (!rst_i_n)
      (in_valid && (fmt[5:2] == 4'b1110) &&
       (opc == OPC_COPYS || opc == OPC_COPYU || opc == OPC_INS)) |=> exc);
  end
endmodule

// File: tb/vem_unit_tb.sv
module vem_unit_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid, wp_en, ld_en;
  logic [31:0]  in_instr, ld_data, xrd_data, mod_mask;
  logic [4:0]   ld_idx, xrd_idx, vrd_idx;
  logic [127:0] vrd_data;
  logic         done, exc;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [127:0] mv [32];
  logic [31:0]  mx [32];
  logic [31:0]  mmask;

  always #10 clk = ~clk;

  vem_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
    .wp_en(wp_en), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .xrd_idx(xrd_idx), .xrd_data(xrd_data), .vrd_idx(vrd_idx),
    .vrd_data(vrd_data), .done(done), .exc(exc), .mod_mask(mod_mask)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input int r, input logic [31:0] v);
    ld_en = 1'b1; ld_idx = 5'(r); ld_data = v;
    @(negedge clk);
    ld_en = 1'b0;
    if (r != 0) mx[r] = v;
    xrd_idx = 5'(r);
    #1 chk("R11 scalar load readback", xrd_data, mx[r]);
  endtask

  // issue one instruction at a falling edge and check the cycle after
  task automatic issue(input logic [3:0] opc, input logic [5:0] fmt, input int src,
                       input int dst, input logic wp, input logic [5:0] hi,
                       input logic ld, input int ldi, input logic [31:0] ldv,
                       input string tag);
    int k, sz, idx, ne, ew;
    bit whole, elem, legal, vw, xw;
    logic [127:0] em, e, r;
    logic [31:0] xr, xsv;
    k = 0;
    while (k < 6 && fmt[5-k]) k++;
    whole = (fmt == 6'b111110);
    elem  = (k <= 3);
    sz  = elem ? k : 0;
    idx = elem ? (int'(fmt) & ((1 << (5 - k)) - 1)) : 0;
    ne  = 16 >> sz;
    ew  = 8 << sz;
    if (whole) legal = (opc == 4'd0);
    else legal = elem && idx < ne && opc >= 1 && opc <= 5 &&
                 !(sz == 3 && opc >= 2 && opc <= 4);
    if (hi != 6'd0) legal = 0;
    em  = (128'd1 << ew) - 128'd1;
    xsv = mx[src];
    e   = (mv[src] >> (idx * ew)) & em;
    r = mv[dst]; xr = '0; vw = 0; xw = 0;
    if (legal) begin
      if (whole) begin r = mv[src]; vw = 1; end
      else case (opc)
        4'd1: begin r = '0; for (int i = 0; i < ne; i++) r |= e << (i * ew); vw = 1; end
        4'd2: begin xr = e[ew-1] ? 32'(e | ~em) : 32'(e); xw = 1; end
        4'd3: begin xr = 32'(e); xw = 1; end
        4'd4: begin r = (mv[dst] & ~(em << (idx*ew))) | (({96'd0, xsv} & em) << (idx*ew)); vw = 1; end
        4'd5: begin r = (mv[dst] & ~(em << (idx*ew))) | ((mv[src] & em) << (idx*ew)); vw = 1; end
        default: ;
      endcase
    end
    in_valid = 1'b1; wp_en = wp;
    in_instr = {hi, opc, fmt, 5'(src), 5'(dst), 6'd0};
    ld_en = ld; ld_idx = 5'(ldi); ld_data = ldv;
    @(negedge clk);
    in_valid = 1'b0; ld_en = 1'b0; in_instr = '0;
    if (ld && ldi != 0) mx[ldi] = ldv;
    if (xw && dst != 0) mx[dst] = xr;
    if (vw) begin mv[dst] = r; if (wp) mmask[dst] = 1'b1; end
    vrd_idx = 5'(dst); xrd_idx = 5'(dst);
    #1;
    chk({tag, " done"}, done, 1'b1);
    chk({tag, " exc"}, exc, !legal);
    chk({tag, " R9 mask"}, mod_mask, mmask);
    chk({tag, " vector"}, vrd_data, mv[dst]);
    chk({tag, " scalar"}, xrd_data, mx[dst]);
    @(negedge clk);
    chk("R12 done drops", done, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R12 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 0; in_instr = '0; wp_en = 0; ld_en = 0;
    ld_idx = '0; ld_data = '0; xrd_idx = '0; vrd_idx = '0; mmask = '0;
    mx[0] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12 reset done", done, 1'b0);
    chk("R12 reset exc", exc, 1'b0);
    chk("R9 reset mask", mod_mask, 32'd0);

    for (int i = 1; i < 32; i++) load(i, 32'h9E3779B9 * 32'(i) ^ 32'h5A5A0F0F);
    xrd_idx = 5'd0; #1 chk("R11 scalar zero", xrd_data, 32'd0);

    // fill every vector with word inserts
    for (int v = 0; v < 32; v++)
      for (int w = 0; w < 4; w++)
        issue(4'd4, 6'b110000 | 6'(w), ((v * 4 + w) % 31) + 1, v, 0, 6'd0, 0, 0, 0, "R5 fill");

    issue(4'd2, 6'b001111, 3, 10, 0, 6'd0, 0, 0, 0, "R3 copys byte15");
    issue(4'd2, 6'b000000, 4, 11, 0, 6'd0, 0, 0, 0, "R3 copys byte0");
    issue(4'd2, 6'b100111, 5, 12, 0, 6'd0, 0, 0, 0, "R3 copys half7");
    issue(4'd2, 6'b110011, 6, 13, 0, 6'd0, 0, 0, 0, "R3 copys word3");
    issue(4'd3, 6'b001011, 3, 14, 0, 6'd0, 0, 0, 0, "R4 copyu byte11");
    issue(4'd3, 6'b100010, 7, 15, 0, 6'd0, 0, 0, 0, "R4 copyu half2");
    issue(4'd3, 6'b110001, 8, 16, 0, 6'd0, 0, 0, 0, "R4 copyu word1");
    issue(4'd2, 6'b000101, 3, 0, 0, 6'd0, 0, 0, 0, "R11 copy to r0");
    issue(4'd4, 6'b000101, 7, 4, 0, 6'd0, 0, 0, 0, "R5 insert byte5");
    issue(4'd4, 6'b100110, 9, 4, 0, 6'd0, 0, 0, 0, "R5 insert half6");
    issue(4'd4, 6'b001111, 0, 4, 0, 6'd0, 0, 0, 0, "R5 insert from r0");
    issue(4'd5, 6'b110010, 6, 5, 0, 6'd0, 0, 0, 0, "R6 insve word2");
    issue(4'd5, 6'b001110, 6, 5, 0, 6'd0, 0, 0, 0, "R6 insve byte14");
    issue(4'd5, 6'b111001, 7, 5, 1, 6'd0, 0, 0, 0, "R6 R10 insve dword1");
    issue(4'd1, 6'b001001, 7, 8, 1, 6'd0, 0, 0, 0, "R7 splat byte9");
    issue(4'd1, 6'b100101, 7, 9, 1, 6'd0, 0, 0, 0, "R7 splat half5");
    issue(4'd1, 6'b110011, 3, 17, 0, 6'd0, 0, 0, 0, "R7 splat word3");
    issue(4'd1, 6'b111000, 3, 18, 1, 6'd0, 0, 0, 0, "R7 R10 splat dword0");
    issue(4'd0, 6'b111110, 9, 20, 1, 6'd0, 0, 0, 0, "R8 move");
    issue(4'd0, 6'b111110, 2, 21, 0, 6'd0, 0, 0, 0, "R8 R9 move no wp");
    issue(4'd0, 6'b111110, 22, 22, 1, 6'd0, 0, 0, 0, "R8 move self");
    issue(4'd0, 6'b111111, 2, 23, 1, 6'd0, 0, 0, 0, "R1 reserved 111111");
    issue(4'd1, 6'b111100, 2, 24, 1, 6'd0, 0, 0, 0, "R1 reserved 111100");
    issue(4'd1, 6'b111101, 2, 25, 1, 6'd0, 0, 0, 0, "R1 reserved 111101");
    issue(4'd1, 6'b010000, 2, 26, 1, 6'd0, 0, 0, 0, "R2 byte idx16");
    issue(4'd4, 6'b101000, 2, 26, 1, 6'd0, 0, 0, 0, "R2 half idx8");
    issue(4'd3, 6'b110100, 2, 26, 0, 6'd0, 0, 0, 0, "R2 word idx4");
    issue(4'd5, 6'b111010, 2, 26, 1, 6'd0, 0, 0, 0, "R2 dword idx2");
    issue(4'd2, 6'b111000, 2, 19, 0, 6'd0, 0, 0, 0, "R10 copys dword");
    issue(4'd3, 6'b111001, 2, 19, 0, 6'd0, 0, 0, 0, "R10 copyu dword");
    issue(4'd4, 6'b111000, 2, 27, 1, 6'd0, 0, 0, 0, "R10 insert dword");
    issue(4'd9, 6'b000011, 2, 27, 1, 6'd0, 0, 0, 0, "R13 bad op elem");
    issue(4'd1, 6'b111110, 2, 27, 1, 6'd0, 0, 0, 0, "R13 bad op whole");
    issue(4'd1, 6'b000011, 2, 27, 1, 6'd1, 0, 0, 0, "R13 spare bits");
    issue(4'd3, 6'b000010, 3, 12, 0, 6'd0, 1, 12, 32'hCAFE0001, "R12 copy beats load");
    issue(4'd4, 6'b000100, 13, 28, 1, 6'd0, 1, 13, 32'h0000_00EE, "R12 insert old scalar");
    xrd_idx = 5'd13; #1 chk("R12 load landed", xrd_data, 32'h0000_00EE);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule